// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block is the timekeeping core of a battery-backed clock. A single-cycle enable pulse arriving at 32.768 kHz is divided down to one pulse per second. That pulse drives a chain of packed-BCD counters for seconds, minutes, hours (24-hour), day of week, date, month and two-digit year. The chain corrects for month lengths and for February in leap years without any help from outside.

A register interface sits around the block. It can overwrite every field at once with a single load pulse. It can hold the oscillator, which freezes all counting. It can also turn on a frequency-test mode, which replaces the least significant bit of the seconds output with a 512 Hz square wave taken from the divider. The outputs are the live counter values. Double buffering and bus decoding sit outside this block.

Top module: `cal_chain_core`

## Requirements
- R1: After reset the fields read year 00, month 01, date 01, day of week 01, hour 00, minute 00 and second 00.
- R2: The seconds field advances once for every 2**DIV_W cycles in which tick_i is high (32768 at the default). Cycles with tick_i low do not count.
- R3: Seconds and minutes count 00 to 59 in packed BCD (upper nibble tens, lower nibble ones). A field at 59 wraps to 00 and carries into the next field.
- R4: Hours count 00 to 23. Leaving 23 wraps the hour to 00 and advances both the day of week and the date in the same cycle.
- R5: Day of week counts 01 to 07, and 07 wraps to 01.
- R6: The date wraps to 01 and the month advances after day 31 of months 01, 03, 05, 07, 08, 10 and 12, and after day 30 of months 04, 06, 09 and 11.
- R7: February ends after day 28 in years not divisible by 4. It ends after day 29 in years divisible by 4, year 00 included.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: While stop_i is 1, no field changes and the divider holds its count. Counting resumes from the held count when stop_i returns to 0.
- R10: A load_i pulse writes every ld_*_i value into its field on the next edge and clears the divider. The first second after a load therefore lasts a full 2**DIV_W ticks.
- R11: While ftest_i is 1 and stop_i is 0, bit 0 of sec_o equals divider bit TEST_BIT (512 Hz at the default rate), and all other output bits are unchanged. With stop_i at 1, sec_o shows the plain count.
- R12: A tick that completes a cascade updates every affected field in the same cycle. From 99-12-31 day 07 at 23:59:59, a single tick gives 00-01-01 day 01 at 00:00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz count enable, one cycle per pulse |
| stop_i | input | 1 | Oscillator stop; 1 halts all counting |
| ftest_i | input | 1 | Frequency-test mode select |
| load_i | input | 1 | Parallel load of all fields |
| ld_sec_i | input | 8 | BCD seconds load value |
| ld_min_i | input | 8 | BCD minutes load value |
| ld_hour_i | input | 8 | BCD hours load value |
| ld_dow_i | input | 8 | BCD day-of-week load value |
| ld_date_i | input | 8 | BCD date load value |
| ld_month_i | input | 8 | BCD month load value |
| ld_year_i | input | 8 | BCD year load value |
| sec_o | output | 8 | Live BCD seconds (bit 0 replaced in test mode) |
| min_o | output | 8 | Live BCD minutes |
| hour_o | output | 8 | Live BCD hours |
| dow_o | output | 8 | Live BCD day of week |
| date_o | output | 8 | Live BCD date |
| month_o | output | 8 | Live BCD month |
| year_o | output | 8 | Live BCD year |

## Verification
The assertions check four things on every cycle. A field at its limit returns to its minimum when it is incremented. Loads land on the next edge. Fields and the divider hold still whenever they are not enabled. The year changes only on a load or at the exact midnight of 1 January. The per-month and leap-year limits, the length of a second after a load, and the timing of the 512 Hz test bit cannot be shown by cycle-local properties. The bench shows these through table-driven one-second steps across month, year and century boundaries and through directed tick-count scenarios.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef logic [7:0] bcd_t;

  localparam int unsigned N_FIELDS = 7;
  localparam int unsigned F_SEC    = 0;
  localparam int unsigned F_MIN    = 1;
  localparam int unsigned F_HOUR   = 2;
  localparam int unsigned F_DOW    = 3;
  localparam int unsigned F_DATE   = 4;
  localparam int unsigned F_MONTH  = 5;
  localparam int unsigned F_YEAR   = 6;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // lowest legal value of a field; also its reset value
  function automatic bcd_t field_min(int unsigned idx);
    case (idx)
      F_DOW, F_DATE, F_MONTH: return 8'h01;
      default:                return 8'h00;
    endcase
  endfunction

  function automatic bcd_t field_fixed_max(int unsigned idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_MONTH:      return 8'h12;
      F_YEAR:       return 8'h99;
      default:      return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned TEST_BIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_pulse_o,
  output logic test_wave_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             step;

  assign step        = tick_i & run_i;
  assign sec_pulse_o = step & (&cnt_q) & ~clear_i;
  assign test_wave_o = cnt_q[TEST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0)); // R10
  AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(tick_i && run_i)) |=> $stable(cnt_q)); // R9
  AST_PULSE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  bcd_t month_i,
  input  bcd_t year_i,
  output bcd_t last_day_o
);
  logic [1:0] mod4;
  logic       leap;

  // 10 = 2 mod 4, so year mod 4 = (2*tens[0] + ones) mod 4
  assign mod4 = year_i[1:0] + {year_i[4], 1'b0};
  assign leap = (mod4 == 2'd0);

  always_comb begin
    case (month_i)
      8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h10, 8'h12: last_day_o = 8'h31;
      8'h02:   last_day_o = leap ? 8'h29 : 8'h28;
      default: last_day_o = 8'h30;
    endcase
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter bcd_t MIN_V = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  bcd_t load_val_i,
  input  logic inc_i,
  input  bcd_t max_i,
  output bcd_t value_o,
  output logic carry_o
);
  bcd_t value_q;
  logic at_end;

  // >= keeps an out-of-range load from running past the limit
  assign at_end  = (value_q >= max_i);
  assign carry_o = inc_i & ~load_i & at_end;
  assign value_o = value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      value_q <= MIN_V;
    else if (load_i)  value_q <= load_val_i;
    else if (inc_i)   value_q <= at_end ? MIN_V : bcd_inc(value_q);
  end

  AST_WRAP_TO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (value_q == MIN_V)); // R3
  AST_LOAD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (value_q == $past(load_val_i))); // R10
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(value_q)); // R9
endmodule

// File: rtl/cal_chain_core.sv
module cal_chain_core
  import cal_pkg::*;
#(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned TEST_BIT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       stop_i,
  input  logic       ftest_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_month_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  bcd_t val   [N_FIELDS];
  bcd_t ld    [N_FIELDS];
  bcd_t lim   [N_FIELDS];
  logic inc   [N_FIELDS];
  logic carry [N_FIELDS];
  logic sec_pulse, test_wave;
  bcd_t last_day;

  initial begin
    if (TEST_BIT >= DIV_W) $error("TEST_BIT must lie inside the divider");
  end

  cal_prescaler #(
    .DIV_W   (DIV_W),
    .TEST_BIT(TEST_BIT)
  ) i_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (~stop_i),
    .clear_i    (load_i),
    .sec_pulse_o(sec_pulse),
    .test_wave_o(test_wave)
  );

  cal_month_len i_month_len (
    .month_i   (val[F_MONTH]),
    .year_i    (val[F_YEAR]),
    .last_day_o(last_day)
  );

  assign ld[F_SEC]   = ld_sec_i;
  assign ld[F_MIN]   = ld_min_i;
  assign ld[F_HOUR]  = ld_hour_i;
  assign ld[F_DOW]   = ld_dow_i;
  assign ld[F_DATE]  = ld_date_i;
  assign ld[F_MONTH] = ld_month_i;
  assign ld[F_YEAR]  = ld_year_i;

  // carry tree: hour end feeds both day of week and date
  assign inc[F_SEC]   = sec_pulse;
  assign inc[F_MIN]   = carry[F_SEC];
  assign inc[F_HOUR]  = carry[F_MIN];
  assign inc[F_DOW]   = carry[F_HOUR];
  assign inc[F_DATE]  = carry[F_HOUR];
  assign inc[F_MONTH] = carry[F_DATE];
  assign inc[F_YEAR]  = carry[F_MONTH];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    if (g == F_DATE) begin : g_dyn
      assign lim[g] = last_day;
    end else begin : g_fix
      assign lim[g] = field_fixed_max(g);
    end

    cal_bcd_field #(
      .MIN_V(field_min(g))
    ) i_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_i),
      .load_val_i(ld[g]),
      .inc_i     (inc[g]),
      .max_i     (lim[g]),
      .value_o   (val[g]),
      .carry_o   (carry[g])
    );
  end

  assign sec_o   = {val[F_SEC][7:1], (ftest_i && !stop_i) ? test_wave : val[F_SEC][0]};
  assign min_o   = val[F_MIN];
  assign hour_o  = val[F_HOUR];
  assign dow_o   = val[F_DOW];
  assign date_o  = val[F_DATE];
  assign month_o = val[F_MONTH];
  assign year_o  = val[F_YEAR];

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> ($stable(val[F_SEC]) && $stable(val[F_MIN]) &&
      $stable(val[F_HOUR]) && $stable(val[F_DOW]) && $stable(val[F_DATE]) &&
      $stable(val[F_MONTH]) && $stable(val[F_YEAR]))); // R9
  AST_YEAR_AT_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(val[F_YEAR]) ||
      (val[F_SEC] == 8'h00 && val[F_MIN] == 8'h00 && val[F_HOUR] == 8'h00 &&
       val[F_DATE] == 8'h01 && val[F_MONTH] == 8'h01))); // R12
  AST_DOW_AFTER_HOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && val[F_HOUR] == 8'h00 && $past(val[F_HOUR]) == 8'h00) |->
      $stable(val[F_DOW])); // R5
endmodule

// File: tb/test_cal_chain_core.sv
`timescale 1ns/1ps
module test_cal_chain_core;
  localparam int unsigned DIV_W    = 7;
  localparam int unsigned TEST_BIT = 5;
  localparam int unsigned SEC_T    = 2 ** DIV_W;
  localparam int unsigned N_VEC    = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, stop_i = 1'b0, ftest_i = 1'b0, load_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_dow_i = '0;
  logic [7:0] ld_date_i = '0, ld_month_i = '0, ld_year_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_chain_core #(.DIV_W(DIV_W), .TEST_BIT(TEST_BIT)) i_cal_chain_core (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
    .ftest_i(ftest_i), .load_i(load_i),
    .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i),
    .ld_dow_i(ld_dow_i), .ld_date_i(ld_date_i), .ld_month_i(ld_month_i),
    .ld_year_i(ld_year_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  // {req, start yy mm dd ww hh mi ss, expected after one second}
  localparam logic [119:0] VEC [N_VEC] = '{
    {8'd3,  56'h23_05_10_03_12_34_56, 56'h23_05_10_03_12_34_57}, // R3 plain step
    {8'd3,  56'h23_09_09_04_09_09_09, 56'h23_09_09_04_09_09_10}, // R3 BCD digit carry
    {8'd3,  56'h23_05_10_03_12_34_59, 56'h23_05_10_03_12_35_00}, // R3 sec wrap
    {8'd4,  56'h23_05_10_03_12_59_59, 56'h23_05_10_03_13_00_00}, // R4 min wrap
    {8'd5,  56'h23_05_10_07_23_59_59, 56'h23_05_11_01_00_00_00}, // R4 R5 midnight
    {8'd6,  56'h23_04_30_02_23_59_59, 56'h23_05_01_03_00_00_00}, // R6 30-day month
    {8'd6,  56'h23_01_31_02_23_59_59, 56'h23_02_01_03_00_00_00}, // R6 31-day month
    {8'd6,  56'h23_11_30_06_23_59_59, 56'h23_12_01_07_00_00_00}, // R6 november
    {8'd7,  56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00}, // R7 non-leap
    {8'd7,  56'h24_02_28_03_23_59_59, 56'h24_02_29_04_00_00_00}, // R7 leap day
    {8'd7,  56'h24_02_29_04_23_59_59, 56'h24_03_01_05_00_00_00}, // R7 leap end
    {8'd7,  56'h00_02_28_01_23_59_59, 56'h00_02_29_02_00_00_00}, // R7 year 00
    {8'd8,  56'h23_12_31_05_23_59_59, 56'h24_01_01_06_00_00_00}, // R8 new year
    {8'd12, 56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00}  // R12 full cascade
  };

  function automatic logic [55:0] now();
    return {year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
  endfunction

  task automatic check(string req, logic [55:0] act, logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(logic [55:0] t);
    {ld_year_i, ld_month_i, ld_date_i, ld_dow_i, ld_hour_i, ld_min_i, ld_sec_i} = t;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", now(), 56'h00_01_01_01_00_00_00);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", now(), 56'h00_01_01_01_00_00_00);

    for (int i = 0; i < N_VEC; i++) begin
      load(VEC[i][111:56]);
      ticks(SEC_T);
      check($sformatf("R%0d table %0d", VEC[i][119:112], i), now(), VEC[i][55:0]);
    end

    // R2 / R10: gaps do not count; load gives a full second
    load(56'h23_05_10_03_12_34_56);
    ticks(100);
    repeat (20) @(negedge clk);
    ticks(SEC_T - 101);
    check("R2 one tick short", now(), 56'h23_05_10_03_12_34_56);
    ticks(1);
    check("R2 exact second", now(), 56'h23_05_10_03_12_34_57);
    ticks(60);
    load(56'h23_05_10_03_12_34_20);
    ticks(SEC_T - 1);
    check("R10 no early step after load", now(), 56'h23_05_10_03_12_34_20);
    ticks(1);
    check("R10 full second after load", now(), 56'h23_05_10_03_12_34_21);

    // R9 stop freezes fields and divider
    load(56'h23_12_31_05_23_59_59);
    stop_i = 1'b1;
    ticks(300);
    check("R9 frozen while stopped", now(), 56'h23_12_31_05_23_59_59);
    stop_i = 1'b0;
    ticks(SEC_T - 1);
    check("R9 divider held", now(), 56'h23_12_31_05_23_59_59);
    ticks(1);
    check("R9 resume", now(), 56'h24_01_01_06_00_00_00);

    // R11 test bit follows divider bit
    ftest_i = 1'b1;
    load(56'h23_05_10_03_12_34_11);
    check("R11 wave low", now(), 56'h23_05_10_03_12_34_10);
    ticks(32);
    check("R11 wave high", now(), 56'h23_05_10_03_12_34_11);
    ticks(32);
    check("R11 wave low again", now(), 56'h23_05_10_03_12_34_10);
    stop_i = 1'b1;
    @(negedge clk);
    check("R11 plain when stopped", now(), 56'h23_05_10_03_12_34_11);
    stop_i = 1'b0;
    ftest_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule